// File: doc/BRIEF.md
# Sample-Rate Timing Select Divider

This block makes the timing strobes that pace the input and output sides of sample-rate conversion channels. Each channel picks one of five clock sources and divides it by one of thirty fixed ratios. The sources are three reference strobes and two base-rate divider strobes. The ratios are not evenly spaced, and a 5-bit index picks one of them. The result is a one-cycle pulse once per divided period. A channel can also bypass the divider and pass the word-select strobe of a serial audio port straight through. This bypass is used when a stream needs no rate conversion.

All source events arrive as one-cycle strobes in the block's clock domain. The channel settings are written through a simple word-wide write port. Two channels share one 32-bit configuration word, one channel per half-word. One more word holds the source-enable bits that gate the divider sources.

Top module: `tsel_timing_divider`

## Requirements
- R1: A channel's 16-bit field holds the source code in bits [11:8] and the divider index in bits [4:0]. Channel 2k sits in bits [15:0] of word k and channel 2k+1 sits in bits [31:16]. The other field bits have no effect. The enable word sits at address NUM_CH/2, and writes to any higher address have no effect.
- R2: Source codes 0 to 4 select `src_tick` bit 0 to bit 4 as the counted event.
- R3: Divider indices 0, 1, 2 and 3 give pulses every 2, 4, 6 and 8 selected events.
- R4: Indices 4 to 28 alternate between 3·2^(i/2) for even i and 2^((i+3)/2) for odd i. This gives 12, 16, 24, 32 and so on up to 32768 at index 27 and 49152 at index 28. Index 29 divides by 98304.
- R5: Divider indices 30 and 31 keep the channel output low.
- R6: With source code s from 0 to 4, counting requires bit s+1 of the enable word. While that bit is clear, the output stays low and the count restarts from zero.
- R7: Source code 6+n with n < NUM_WS forwards `ws_tick[n]` to the output one cycle later and ignores the index. Code 5 and codes 6+n with n ≥ NUM_WS keep the output low.
- R8: In divider mode, the output is a single-cycle pulse. It rises one cycle after the event that completes each group of divisor events.
- R9: A write to a configuration word restarts counting from zero for both of its channels. No pulse comes out in the cycle after that write.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address: channel pairs, then the enable word |
| wr_data | input | 32 | Write data |
| src_tick | input | 5 | One-cycle event strobes of the five divider sources |
| ws_tick | input | NUM_WS | Word-select strobes of the serial ports |
| tick_out | output | NUM_CH | Timing pulse per channel |

## Verification
Every result appears exactly one clock edge after the cycle that causes it. A counted event that completes a divisor group, a forwarded word-select strobe, and the silence after a configuration write all follow this rule. A new configuration or enable value governs from the cycle after its write. The bench drives each cycle's inputs at the falling edge and predicts that cycle's outcome from a reference model. The model uses the bench's own divisor table and is updated with the old configuration before any write in the same cycle is applied. The bench compares the outputs at the following falling edge, so every comparison falls one full edge after its cause.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int NUM_SRC  = 5;
  localparam int SRC_W    = 4;
  localparam int IDX_W    = 5;
  localparam int CNT_W    = 17;
  localparam int LAST_IDX = 29;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [IDX_W-1:0] idx;
  } ch_cfg_t;

  // Terminal count (divisor - 1) for a divider index.
  function automatic logic [CNT_W-1:0] tsel_term(input logic [IDX_W-1:0] idx);
    logic [CNT_W-1:0] d;
    if (idx < 5'd4)
      d = CNT_W'({idx + 5'd1, 1'b0});
    else if (idx == 5'(LAST_IDX))
      d = CNT_W'(98304);
    else if (idx[0] == 1'b0)
      d = CNT_W'(3) << idx[4:1];
    else
      d = CNT_W'(1) << (idx[4:1] + 4'd2);
    return d - CNT_W'(1);
  endfunction

endpackage

// File: rtl/tsel_cfg_regs.sv
module tsel_cfg_regs
  import tsel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [31:0]                  wr_data,
  output ch_cfg_t [NUM_CH-1:0]         cfg_o,
  output logic [NUM_SRC:0]             en_o,
  output logic [NUM_CH-1:0]            clr_o
);

  localparam int NUM_PAIRS = NUM_CH / 2;

  ch_cfg_t [NUM_CH-1:0] cfg_q, cfg_d;
  logic [NUM_SRC:0]     en_q, en_d;

  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    clr_o = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (wr_en && (wr_addr == ADDR_W'(p))) begin
        cfg_d[2*p].src   = wr_data[11:8];
        cfg_d[2*p].idx   = wr_data[4:0];
        cfg_d[2*p+1].src = wr_data[27:24];
        cfg_d[2*p+1].idx = wr_data[20:16];
        clr_o[2*p]       = 1'b1;
        clr_o[2*p+1]     = 1'b1;
      end
    end
    if (wr_en && (wr_addr == ADDR_W'(NUM_PAIRS)))
      en_d = wr_data[NUM_SRC:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;

  // R1: a write to a pair word lands in both of its channel fields
  p_pair_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> (cfg_q[0].idx == $past(wr_data[4:0]) &&
                                  cfg_q[1].src == $past(wr_data[27:24])));

endmodule

// File: rtl/tsel_src_mux.sv
module tsel_src_mux
  import tsel_pkg::*;
#(
  parameter int NUM_WS = 8
) (
  input  ch_cfg_t             cfg_i,
  input  logic [NUM_SRC:0]    en_i,
  input  logic [NUM_SRC-1:0]  src_tick_i,
  input  logic [NUM_WS-1:0]   ws_tick_i,
  output logic                tick_o,
  output logic                div_mode_o,
  output logic                pass_mode_o
);

  logic idx_ok;
  assign idx_ok = (cfg_i.idx <= 5'(LAST_IDX));

  always_comb begin
    tick_o      = 1'b0;
    div_mode_o  = 1'b0;
    pass_mode_o = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cfg_i.src == SRC_W'(s)) begin
        tick_o     = src_tick_i[s];
        div_mode_o = en_i[s+1] && idx_ok;
      end
    end
    for (int n = 0; n < NUM_WS; n++) begin
      if (cfg_i.src == SRC_W'(6 + n)) begin
        tick_o      = ws_tick_i[n];
        pass_mode_o = 1'b1;
      end
    end
  end

  // R7: the two modes never overlap
  p_mode_excl_r7: assert final (!(div_mode_o && pass_mode_o));

endmodule

// File: rtl/tsel_ch_div.sv
module tsel_ch_div
  import tsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              div_mode_i,
  input  logic              pass_mode_i,
  input  logic              tick_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              pulse_o
);

  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pls_q, pls_d;
  logic             cnt_en;

  assign term   = tsel_term(idx_i);
  assign cnt_en = div_mode_i && tick_i;

  always_comb begin
    cnt_d = cnt_q;
    pls_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (div_mode_i) begin
      if (cnt_en) begin
        if (cnt_q == term) begin
          cnt_d = '0;
          pls_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end else begin
      cnt_d = '0;
      pls_d = pass_mode_i && tick_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign pulse_o = pls_q;

  // R4: the count never passes the selected terminal value
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode_i |-> (cnt_q <= term));

  // R8: every pulse follows an event seen one cycle earlier
  p_pulse_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q |-> $past(tick_i));

  // R8: a divider pulse leaves the count at zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_q && $past(div_mode_i)) |-> (cnt_q == '0));

  // R9: a configuration write clears the channel
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !pls_q));

endmodule

// File: rtl/tsel_timing_divider.sv
module tsel_timing_divider
  import tsel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_WS = 8,
  localparam int ADDR_W = $clog2(NUM_CH / 2 + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [NUM_SRC-1:0]  src_tick,
  input  logic [NUM_WS-1:0]   ws_tick,
  output logic [NUM_CH-1:0]   tick_out
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_SRC:0]     en;
  logic [NUM_CH-1:0]    clr;
  logic [NUM_CH-1:0]    ch_tick, ch_div, ch_pass;

  tsel_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .en_o    (en),
    .clr_o   (clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsel_src_mux #(.NUM_WS(NUM_WS)) u_mux (
      .cfg_i       (cfg[c]),
      .en_i        (en),
      .src_tick_i  (src_tick),
      .ws_tick_i   (ws_tick),
      .tick_o      (ch_tick[c]),
      .div_mode_o  (ch_div[c]),
      .pass_mode_o (ch_pass[c])
    );
    tsel_ch_div u_div (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .clr_i       (clr[c]),
      .div_mode_i  (ch_div[c]),
      .pass_mode_i (ch_pass[c]),
      .tick_i      (ch_tick[c]),
      .idx_i       (cfg[c].idx),
      .pulse_o     (tick_out[c])
    );

    // R5: an idle channel (no valid mode) is silent one cycle later
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!ch_div[c] && !ch_pass[c]) |=> !tick_out[c]);
  end

  // R10: reset holds every output low
  p_reset_low_r10: assert property (@(posedge clk)
    !rst_int_n |-> (tick_out == '0));

endmodule

// File: tb/tsel_timing_divider_tb.sv
module tsel_timing_divider_tb;

  localparam int NCH = 4;
  localparam int NWS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  src_tick = '0;
  logic [NWS-1:0] ws_tick = '0;
  logic [NCH-1:0] tick_out;

  int n_cmp = 0;
  int n_bad = 0;

  int m_src [NCH];
  int m_idx [NCH];
  int m_cnt [NCH];
  bit m_exp [NCH];
  bit [5:0] m_en = '0;

  always #10 clk = ~clk;

  tsel_timing_divider #(.NUM_CH(NCH), .NUM_WS(NWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_tick(src_tick), .ws_tick(ws_tick),
    .tick_out(tick_out));

  // Divisor table built from the stepping rule.
  function automatic int exp_div(int idx);
    int d = 2;
    int st = 2;
    for (int i = 0; i < idx; i++) begin
      if (i > 2 && (i % 2) == 1) st = st * 2;
      if (i == 28) begin d = d + st; st = st * 2; end
      d = d + st;
    end
    return d;
  endfunction

  task automatic check(input bit got, input bit exp, input string req, input int ch);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d got %0b expected %0b at %0t", req, ch, got, exp, $time);
    end
  endtask

  // One cycle: predict from current inputs, apply writes, compare after the edge.
  task automatic cyc(input string req);
    for (int c = 0; c < NCH; c++) begin
      bit hit = wr_en && (wr_addr == 2'(c / 2));
      if (hit) begin
        m_cnt[c] = 0; m_exp[c] = 0;
      end else if (m_src[c] < 5) begin
        if (!(m_en[m_src[c] + 1] && m_idx[c] < 30)) begin
          m_cnt[c] = 0; m_exp[c] = 0;
        end else if (src_tick[m_src[c]]) begin
          if (m_cnt[c] == exp_div(m_idx[c]) - 1) begin
            m_cnt[c] = 0; m_exp[c] = 1;
          end else begin
            m_cnt[c]++; m_exp[c] = 0;
          end
        end else m_exp[c] = 0;
      end else if (m_src[c] >= 6 && m_src[c] - 6 < NWS) begin
        m_cnt[c] = 0; m_exp[c] = ws_tick[m_src[c] - 6];
      end else begin
        m_cnt[c] = 0; m_exp[c] = 0;
      end
    end
    if (wr_en) begin
      if (wr_addr < 2) begin
        for (int h = 0; h < 2; h++) begin
          m_src[2*wr_addr + h] = int'(wr_data[16*h + 8 +: 4]);
          m_idx[2*wr_addr + h] = int'(wr_data[16*h +: 5]);
        end
      end else if (wr_addr == 2) m_en = wr_data[5:0];
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(tick_out[c], m_exp[c], req, c);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(req);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pair(int s0, int i0, int s1, int i1);
    return {4'h0, 4'(s1), 3'b000, 5'(i1), 4'h0, 4'(s0), 3'b000, 5'(i0)};
  endfunction

  task automatic run(input int n, input bit rnd, input string req);
    for (int k = 0; k < n; k++) begin
      if (rnd) begin
        src_tick = 5'($urandom);
        ws_tick  = NWS'($urandom);
      end
      cyc(req);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = 0; m_idx[c] = 0; m_cnt[c] = 0; m_exp[c] = 0;
    end
    src_tick = '1;
    ws_tick  = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check(tick_out[c], 1'b0, "R10", c);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) check(tick_out[c], 1'b0, "R10", c);
    src_tick = '0; ws_tick = '0;

    // R3 and R2: small divisors, different sources per channel
    wr(2'd2, 32'h0000_003E, "R6");
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, pair(0, i, 1, i), "R3");
      wr(2'd1, pair(2, i, 4, 3 - i), "R2");
      src_tick = 5'b1_0111;
      run(40, 1'b0, "R3");
      run(40, 1'b1, "R2");
    end

    // R4: mid-range divisors
    wr(2'd0, pair(3, 4, 0, 5), "R4");
    wr(2'd1, pair(1, 6, 2, 9), "R4");
    src_tick = '1;
    run(700, 1'b0, "R4");

    // R5: reserved indices
    wr(2'd0, pair(0, 30, 1, 31), "R5");
    run(20, 1'b0, "R5");

    // R6: enable gating, then re-enable mid-stream
    wr(2'd0, pair(0, 1, 4, 0), "R6");
    wr(2'd2, 32'h0000_001D, "R6");
    run(20, 1'b0, "R6");
    wr(2'd2, 32'h0000_0021, "R6");
    run(20, 1'b1, "R6");

    // R7: word-select pass-through and dead codes
    wr(2'd0, pair(6, 3, 13, 0), "R7");
    wr(2'd1, pair(5, 0, 14, 0), "R7");
    run(60, 1'b1, "R7");
    wr(2'd1, pair(15, 0, 9, 31), "R7");
    run(30, 1'b1, "R7");

    // R1: stray field bits and an unmapped address
    wr(2'd2, 32'hFFFF_FFFF, "R1");
    wr(2'd0, 32'hF0E0_F0E0 | pair(0, 2, 1, 1), "R1");
    src_tick = '1;
    run(25, 1'b0, "R1");
    wr(2'd3, 32'h0000_0000, "R1");
    run(25, 1'b0, "R1");

    // R9: rewrite mid-count restarts both channels of the word
    wr(2'd0, pair(0, 3, 1, 3), "R9");
    run(5, 1'b0, "R9");
    wr(2'd0, pair(0, 3, 1, 3), "R9");
    run(20, 1'b0, "R9");

    // R8: random configurations and event patterns
    for (int blk = 0; blk < 80; blk++) begin
      case ($urandom_range(0, 2))
        0: wr(2'd0, pair($urandom_range(0, 15), $urandom_range(0, 7),
                         $urandom_range(0, 15), $urandom_range(0, 7)), "R8");
        1: wr(2'd1, pair($urandom_range(0, 15), $urandom_range(0, 7),
                         $urandom_range(0, 15), $urandom_range(0, 31)), "R8");
        default: wr(2'd2, $urandom, "R8");
      endcase
      run(40, 1'b1, "R8");
    end

    // R4: the two largest divisors, counted on a steady event stream
    wr(2'd2, 32'h0000_003E, "R4");
    wr(2'd0, pair(0, 28, 0, 29), "R4");
    wr(2'd1, pair(0, 27, 3, 29), "R4");
    src_tick = '1;
    run(exp_div(29) + 20, 1'b0, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule